// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a word clock and one data line, and turns it into pairs of 32-bit samples in the system clock domain. The three serial wires are sampled by the system clock through synchronizers. The rising edges of the bit clock are found inside the system clock domain, so all state lives in one domain and the results are already synchronous when they leave the block. The system clock must be several times faster than the bit clock.

A static format input selects one of two framings: I2S framing or left-justified framing. A static word-length input selects 16-, 24- or 32-bit words. The block measures each half of the word-clock period in bit clocks. A frame is accepted when both halves are equal and the whole period is 32, 48 or 64 bit clocks. A run of unacceptable frames raises an error flag, and the emitted samples are then forced to zero. The flag clears as soon as the clocks line up again.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data and the word clock are taken only at rising edges of the bit clock. Changes on the data line between rising edges have no effect on the captured samples.
- R2: With `fmt_lj` high, the word clock is high for the left channel and low for the right channel. The most significant bit of a word is taken on the first rising edge that sees the new word-clock level.
- R3: With `fmt_lj` low (I2S), the word clock is low for the left channel and high for the right channel. The most significant bit is taken on the second rising edge after the level change. The first edge carries the last bit of the previous slot.
- R4: `wlen_sel` selects the word length: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. Words are two's complement and sent most significant bit first. Each word is placed at the top of the 32-bit result with zero-filled lower bits. Slot bits beyond the word length are ignored.
- R5: Frames of 32, 48 and 64 bit clocks per word-clock period are all received correctly, for both framings.
- R6: Each completed left-then-right pair produces exactly one one-cycle `pcm_valid` pulse, after the right-channel word has ended. A pair whose left slot was not seen from its start is not emitted.
- R7: A frame counts as good only if its left and right halves are equal in bit clocks and together total 32, 48 or 64. The frame is judged when the word clock returns to the left level.
- R8: `frame_err` rises on the fifth bad frame in a row and not before. While it is high, emitted samples are zero. Up to four consecutive bad frames still pass their data.
- R9: The first good frame clears `frame_err`, and that frame's pair carries its real data.
- R10: After reset, `pcm_valid` and `frame_err` are low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Serial word (channel) clock, asynchronous |
| sdata_in | input | 1 | Serial audio data |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| wlen_sel | input | 2 | Word length: 0 = 16, 1 = 24, 2/3 = 32 bits |
| pcm_left | output | 32 | Left sample, left-aligned |
| pcm_right | output | 32 | Right sample, left-aligned |
| pcm_valid | output | 1 | One-cycle strobe for a new sample pair |
| frame_err | output | 1 | Persistent clock-relationship error |

## Verification
A wrong slot bit index or a wrong framing offset shows up on the very next `pcm_valid` pulse. The sample appears shifted by one bit or truncated at the wrong length, so every vector compares both channels bit for bit. A half-period counter that is off by one, or a streak counter that is off by one, moves the error onset by a whole frame. For that reason the bench checks the flag and the zeroed data on the fourth, fifth and sixth bad frames, and checks recovery on the first good one. A lost or spurious pair is caught by counting strobes for each burst.

// File: rtl/sairx_pkg.sv
package sairx_pkg;

  localparam int SAMPLE_W = 32;
  localparam int POS_W    = $clog2(2 * SAMPLE_W + 1);

  typedef enum logic [1:0] {
    WLEN_16  = 2'd0,
    WLEN_24  = 2'd1,
    WLEN_32  = 2'd2,
    WLEN_32X = 2'd3
  } wlen_e;

  // Number of bits per word for a word-length code.
  function automatic int wlen_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WLEN_16: return 16;
      WLEN_24: return 24;
      default: return 32;
    endcase
  endfunction

  // Put one serial bit at slot position idx (0 = MSB) if it is inside the word.
  function automatic logic [SAMPLE_W-1:0] place_bit(
      input logic [SAMPLE_W-1:0] w,
      input logic [POS_W-1:0]    idx,
      input logic                b,
      input logic [1:0]          sel);
    logic [SAMPLE_W-1:0] r;
    r = w;
    if (int'(idx) < wlen_bits(sel)) r[SAMPLE_W - 1 - int'(idx)] = b;
    return r;
  endfunction

  // A frame is good when the halves match and the period is 32, 48 or 64.
  function automatic logic frame_legal(input logic [POS_W-1:0] l,
                                       input logic [POS_W-1:0] r);
    return (l == r) && ((int'(l) == 16) || (int'(l) == 24) || (int'(l) == 32));
  endfunction

endpackage

// File: rtl/sairx_sync.sv
module sairx_sync #(
  parameter int N_SIG  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] async_in,
  output logic [N_SIG-1:0] sync_out
);

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], async_in[s]};
    end
    assign sync_out[s] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/sairx_slot_capture.sv
module sairx_slot_capture
  import sairx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                ws_edge,
  input  logic                new_left,
  input  logic                fmt_lj,
  input  logic [1:0]          wlen_sel,
  input  logic                sdata,
  output logic                slot_done,
  output logic                done_left,
  output logic                done_active,
  output logic [SAMPLE_W-1:0] done_word
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [SAMPLE_W-1:0] word_q;
  logic [POS_W-1:0]    idx_q;
  logic                chan_left_q;
  logic                active_q;
  logic [SAMPLE_W-1:0] word_tail;
  logic [SAMPLE_W-1:0] word_head;

  // Current bit placed into the running slot.
  assign word_tail = place_bit(word_q, idx_q, sdata, wlen_sel);
  // Current bit as the MSB of a fresh slot (left-justified framing).
  assign word_head = place_bit('0, '0, sdata, wlen_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      idx_q       <= '0;
      chan_left_q <= 1'b0;
      active_q    <= 1'b0;
      slot_done   <= 1'b0;
      done_left   <= 1'b0;
      done_active <= 1'b0;
      done_word   <= '0;
    end else begin
      slot_done <= 1'b0;
      if (bit_stb) begin
        if (ws_edge) begin
          slot_done   <= 1'b1;
          done_left   <= chan_left_q;
          done_active <= active_q;
          // I2S: the edge bit is the tail of the ending slot.
          done_word   <= fmt_lj ? word_q : word_tail;
          chan_left_q <= new_left;
          active_q    <= 1'b1;
          if (fmt_lj) begin
            word_q <= word_head;
            idx_q  <= POS_W'(1);
          end else begin
            word_q <= '0;
            idx_q  <= '0;
          end
        end else begin
          word_q <= word_tail;
          if (idx_q != POS_MAX) idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R6
  slot_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> !slot_done);

  // R2
  lj_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && ws_edge && fmt_lj) |=> (idx_q == POS_W'(1)));

endmodule

// File: rtl/sairx_frame_monitor.sv
module sairx_frame_monitor
  import sairx_pkg::*;
#(
  parameter int BAD_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic ws_edge,
  input  logic new_left,
  output logic frame_err,
  output logic eval_stb,
  output logic eval_good
);

  localparam int STREAK_W = $clog2(BAD_LIMIT + 2);
  localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(BAD_LIMIT + 1);
  localparam logic [POS_W-1:0]    CNT_MAX    = '1;

  logic [POS_W-1:0]    half_q;
  logic [POS_W-1:0]    left_len_q;
  logic                armed_q;
  logic                left_ok_q;
  logic [STREAK_W-1:0] streak_q;
  logic [STREAK_W-1:0] streak_inc;
  logic                eval_now;
  logic                good_now;

  assign eval_now   = bit_stb && ws_edge && armed_q && new_left && left_ok_q;
  assign good_now   = frame_legal(left_len_q, half_q);
  assign streak_inc = (streak_q == STREAK_MAX) ? streak_q : streak_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= '0;
      left_len_q <= '0;
      armed_q    <= 1'b0;
      left_ok_q  <= 1'b0;
      streak_q   <= '0;
      frame_err  <= 1'b0;
      eval_stb   <= 1'b0;
      eval_good  <= 1'b0;
    end else begin
      eval_stb <= eval_now;
      if (eval_now) eval_good <= good_now;
      if (bit_stb) begin
        if (ws_edge) begin
          if (new_left) begin
            left_ok_q <= 1'b0;
          end else begin
            left_len_q <= half_q;
            left_ok_q  <= armed_q;
          end
          half_q  <= POS_W'(1);
          armed_q <= 1'b1;
        end else if (half_q != CNT_MAX) begin
          half_q <= half_q + 1'b1;
        end
      end
      if (eval_now) begin
        if (good_now) begin
          streak_q  <= '0;
          frame_err <= 1'b0;
        end else begin
          streak_q  <= streak_inc;
          frame_err <= (int'(streak_inc) > BAD_LIMIT);
        end
      end
    end
  end

  // R9
  good_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && eval_good) |-> !frame_err);

  // R8
  err_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> (eval_stb && !eval_good));

  // R8
  err_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !(eval_stb && eval_good)) |=> (frame_err || (eval_stb && eval_good)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sairx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BAD_LIMIT   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic                sdata_in,
  input  logic                fmt_lj,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic                pcm_valid,
  output logic                frame_err
);

  logic [2:0]          sync_v;
  logic                bck_s, ws_s, dat_s;
  logic                bck_d_q;
  logic                ws_prev_q;
  logic                have_ws_q;
  logic                bit_stb;
  logic                ws_edge;
  logic                new_left;
  logic                slot_done;
  logic                done_left;
  logic                done_active;
  logic [SAMPLE_W-1:0] done_word;
  logic                eval_stb;
  logic                eval_good;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                left_rdy_q;
  logic                right_done;
  logic                pair_fire;

  sairx_sync #(.N_SIG(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdata_in, wclk_in, bclk_in}),
    .sync_out (sync_v)
  );

  assign bck_s = sync_v[0];
  assign ws_s  = sync_v[1];
  assign dat_s = sync_v[2];

  assign bit_stb  = bck_s && !bck_d_q;
  assign ws_edge  = have_ws_q && (ws_s != ws_prev_q);
  // Left level is high for left-justified framing, low for I2S.
  assign new_left = (ws_s == fmt_lj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d_q   <= 1'b0;
      ws_prev_q <= 1'b0;
      have_ws_q <= 1'b0;
    end else begin
      bck_d_q <= bck_s;
      if (bit_stb) begin
        ws_prev_q <= ws_s;
        have_ws_q <= 1'b1;
      end
    end
  end

  sairx_slot_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .ws_edge     (ws_edge),
    .new_left    (new_left),
    .fmt_lj      (fmt_lj),
    .wlen_sel    (wlen_sel),
    .sdata       (dat_s),
    .slot_done   (slot_done),
    .done_left   (done_left),
    .done_active (done_active),
    .done_word   (done_word)
  );

  sairx_frame_monitor #(.BAD_LIMIT(BAD_LIMIT)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .ws_edge   (ws_edge),
    .new_left  (new_left),
    .frame_err (frame_err),
    .eval_stb  (eval_stb),
    .eval_good (eval_good)
  );

  assign right_done = slot_done && !done_left;
  assign pair_fire  = right_done && done_active && left_rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold_q <= '0;
      left_rdy_q  <= 1'b0;
      pcm_left    <= '0;
      pcm_right   <= '0;
      pcm_valid   <= 1'b0;
    end else begin
      pcm_valid <= pair_fire;
      if (slot_done) begin
        if (done_left) begin
          left_hold_q <= done_word;
          left_rdy_q  <= done_active;
        end else begin
          left_rdy_q <= 1'b0;
        end
      end
      if (pair_fire) begin
        pcm_left  <= frame_err ? '0 : left_hold_q;
        pcm_right <= frame_err ? '0 : done_word;
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  // R6
  valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(right_done));

  // R8
  err_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && frame_err) |-> (pcm_left == '0 && pcm_right == '0));

  // R1
  edge_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> $past(bit_stb));

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic        fmt = 1'b1;
  logic [1:0]  wl = 2'd0;
  logic [31:0] pcm_left, pcm_right;
  logic        pcm_valid, frame_err;

  always #2 clk = ~clk;  // 250 MHz

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .wclk_in(wclk), .sdata_in(sdata),
    .fmt_lj(fmt), .wlen_sel(wl), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_valid(pcm_valid), .frame_err(frame_err)
  );

  int n_cmp = 0, n_bad = 0, n_valid = 0;
  logic done = 1'b0;
  logic pend = 1'b0;
  logic [31:0] cap_l [0:63];
  logic [31:0] cap_r [0:63];
  logic        cap_e [0:63];

  always @(negedge clk) begin
    if (rst_n && pcm_valid && n_valid < 64) begin
      cap_l[n_valid] = pcm_left;
      cap_r[n_valid] = pcm_right;
      cap_e[n_valid] = frame_err;
      n_valid = n_valid + 1;
    end
  end

  // {fmt_lj, wlen code, half length, left, right}
  localparam logic [72:0] VECS [0:7] = '{
    {1'b1, 2'd0, 6'd16, 32'h8001_2345, 32'h7FFE_9876},
    {1'b1, 2'd1, 6'd24, 32'hA5C3_F1E7, 32'h1234_5678},
    {1'b1, 2'd2, 6'd32, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
    {1'b1, 2'd0, 6'd32, 32'hC0DE_FFFF, 32'h4321_AAAA},
    {1'b0, 2'd0, 6'd16, 32'h9ABC_0000, 32'h6DEF_0000},
    {1'b0, 2'd1, 6'd32, 32'hF00D_CAFE, 32'h8BAD_F00D},
    {1'b0, 2'd2, 6'd32, 32'h8000_0001, 32'hFFFF_FFFE},
    {1'b0, 2'd0, 6'd24, 32'h5A5A_C3C3, 32'hE1E1_7777}
  };

  function automatic logic [31:0] trunc(input logic [31:0] v, input logic [1:0] code);
    int keep;
    keep = (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
    return (v >> (32 - keep)) << (32 - keep);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic f, input logic [1:0] w);
    rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; sdata = 1'b0; pend = 1'b0;
    fmt = f; wl = w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // One bit clock period; the data line toggles while the bit clock is high.
  task automatic bit_out(input logic ws, input logic b);
    @(negedge clk);
    bclk = 1'b0; wclk = ws;
    if (fmt) sdata = b;
    else begin sdata = pend; pend = b; end
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    sdata = ~sdata;  // R1 noise between rising edges
    @(negedge clk);
  endtask

  task automatic send_half(input logic ws, input int h, input logic [31:0] v);
    for (int j = 0; j < h; j++) bit_out(ws, (j < 32) ? v[31 - j] : 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 2'd0);
    // R10 reset state
    check("R10 valid", {31'd0, pcm_valid}, 32'd0);
    check("R10 err", {31'd0, frame_err}, 32'd0);
    check("R10 left", pcm_left, 32'd0);
    check("R10 right", pcm_right, 32'd0);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [72:0] v;
      logic lvl_l;
      int base, h;
      v = VECS[i];
      do_reset(v[72], v[71:70]);
      lvl_l = v[72];
      h = int'(v[69:64]);
      base = n_valid;
      send_half(~lvl_l, h, 32'd0);
      send_half(lvl_l, h, v[63:32]);
      send_half(~lvl_l, h, v[31:0]);
      send_half(lvl_l, 4, 32'd0);
      repeat (8) @(negedge clk);
      check(v[72] ? "R6 R5 LJ pair count" : "R6 R5 I2S pair count", n_valid - base, 1);
      check(v[72] ? "R2 R4 R1 left" : "R3 R4 R1 left", cap_l[base], trunc(v[63:32], v[71:70]));
      check(v[72] ? "R2 R4 R1 right" : "R3 R4 R1 right", cap_r[base], trunc(v[31:0], v[71:70]));
    end

    // Error persistence and recovery: R7 R8 R9
    begin
      int base;
      logic [31:0] pat [0:7];
      int hl [0:7];
      int hr [0:7];
      for (int k = 0; k < 8; k++) begin
        pat[k] = 32'h1357_0000 + 32'h1111_0000 * k[31:0];
        hl[k] = (k < 3) ? 16 : (k < 6) ? 20 : 16;
        hr[k] = (k < 6) ? 20 : 16;
      end
      do_reset(1'b1, 2'd0);
      base = n_valid;
      send_half(1'b0, 16, 32'd0);
      for (int k = 0; k < 8; k++) begin
        send_half(1'b1, hl[k], pat[k]);
        send_half(1'b0, hr[k], ~pat[k]);
      end
      send_half(1'b1, 4, 32'd0);
      repeat (8) @(negedge clk);
      check("R6 R7 pair count", n_valid - base, 8);
      check("R7 unequal halves pass data", cap_l[base], trunc(pat[0], 2'd0));
      check("R8 no err at 4 bad", {31'd0, cap_e[base + 3]}, 32'd0);
      check("R8 data at 4 bad", cap_r[base + 3], trunc(~pat[3], 2'd0));
      check("R8 err at 5 bad", {31'd0, cap_e[base + 4]}, 32'd1);
      check("R8 zero left at 5 bad", cap_l[base + 4], 32'd0);
      check("R8 zero right at 6 bad", cap_r[base + 5], 32'd0);
      check("R9 err cleared", {31'd0, cap_e[base + 6]}, 32'd0);
      check("R9 data back", cap_l[base + 6], trunc(pat[6], 2'd0));
      check("R9 err port low", {31'd0, frame_err}, 32'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule